// File: doc/BRIEF.md
# High-Order Multiframe Overhead Receiver

This block sits on the receive side of one high-order member of a virtually concatenated group. Once per 125 µs frame it is handed the path-overhead byte that carries the concatenation multiframe signalling, along with a one-cycle valid strobe. The block finds and follows the 16-frame multiframe using a 4-bit frame counter that the far end increments on every frame. From nibbles sent at fixed frame positions, it rebuilds the 8-bit multiframe count and the 8-bit member sequence number.

It presents a 12-bit multiframe index, made of the multiframe count above the frame count, which wraps after 4096 frames (512 ms). It also presents the sequence number, an in-frame flag, its inverse as a loss-of-multiframe flag, and an error flag. The error flag is raised when a received multiframe count disagrees with the locally advanced one. Downstream deskew logic uses the index to align members, and group logic uses the sequence number to order them.

Top module: `hovcat_rx`

## Requirements
- R1: In each overhead byte, bits [3:0] carry the frame count and bits [7:4] carry a data nibble. The data nibble holds the multiframe count high nibble at frame count 0, its low nibble at frame count 1, the sequence number high nibble at frame count 14, and its low nibble at frame count 15.
- R2: While out of lock, a byte "matches" when its frame count equals the previous byte's frame count plus one, modulo 16. The first byte after reset never matches. `in_frame` rises in the cycle after the second consecutive matching byte, and a non-matching byte restarts the count.
- R3: While in lock, the expected frame count advances by one on every strobe, whatever is received. Three consecutive bytes that differ from it drop lock in the cycle after the third. A matching byte clears the mismatch run.
- R4: While in lock, `mf_index[3:0]` shows the expected frame count of the latest strobe. When it moves from 15 to 0, `mf_index[11:4]` advances by one. While out of lock, `mf_index[3:0]` shows the received frame count.
- R5: The received multiframe count is loaded into `mf_index[11:4]` only by a matching in-lock byte at frame 1, and only if the byte directly before it was a matching in-lock byte at frame 0.
- R6: `seq_num` is loaded only by a matching in-lock byte at frame 15, and only if the byte directly before it was a matching in-lock byte at frame 14.
- R7: On each load of the multiframe count, `mfi2_err` is set if a count has already been loaded since lock and the new value differs from the locally advanced value, and it is cleared otherwise.
- R8: After reset, all outputs are zero except `loss_mf`, which is 1. `loss_mf` is always the inverse of `in_frame`, and outputs change only in the cycle after a strobe.
- R9: Loss of lock clears `mfi2_err`, drops any pending nibbles and forgets the loaded count. The next load after relock therefore cannot raise the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h4_vld | input | 1 | One-cycle strobe, overhead byte present |
| h4_byte | input | 8 | Received overhead byte |
| mf_index | output | 12 | Multiframe count above frame count |
| seq_num | output | 8 | Reassembled member sequence number |
| in_frame | output | 1 | Multiframe lock held |
| loss_mf | output | 1 | Multiframe lock absent |
| mfi2_err | output | 1 | Last received multiframe count disagreed with local count |

## Verification
Several rules are checked on every cycle by assertions: the frame count steps by one per strobe in lock, the multiframe count carries on a 15-to-0 wrap, outputs hold steady between strobes, lock only changes on a strobe, and the error flag never stands outside lock. The exact lock and unlock thresholds, the position-gated loading of both reassembled fields, and the error decision on a jumped count need the bench's scenarios. These scenarios are directed corruptions and random streams with bursts, slips and count jumps, and they are compared against a reference model.

// File: rtl/hovcat_rx.sv
module hovcat_rx #(
  parameter int LOCK_GOOD = 2,
  parameter int LOSS_BAD  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h4_vld,
  input  logic [7:0]  h4_byte,
  output logic [11:0] mf_index,
  output logic [7:0]  seq_num,
  output logic        in_frame,
  output logic        loss_mf,
  output logic        mfi2_err
);
  localparam int CW = $clog2(LOCK_GOOD + LOSS_BAD + 1);

  logic [3:0]    rx_fc, rx_nib, exp_fc, cur_fc, hi_nib, sq_nib;
  logic [7:0]    mfc;
  logic [CW-1:0] good_cnt, bad_cnt;
  logic          have_prev, hi_ok, sq_ok, mfc_known, match;

  assign rx_fc    = h4_byte[3:0];
  assign rx_nib   = h4_byte[7:4];
  assign match    = (rx_fc == exp_fc);
  assign mf_index = {mfc, cur_fc};
  assign loss_mf  = ~in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_fc <= '0; cur_fc <= '0; hi_nib <= '0; sq_nib <= '0;
      mfc <= '0; seq_num <= '0; good_cnt <= '0; bad_cnt <= '0;
      have_prev <= 1'b0; hi_ok <= 1'b0; sq_ok <= 1'b0;
      mfc_known <= 1'b0; in_frame <= 1'b0; mfi2_err <= 1'b0;
    end else if (h4_vld) begin
      if (!in_frame) begin
        cur_fc    <= rx_fc;
        exp_fc    <= rx_fc + 4'd1;
        have_prev <= 1'b1;
        hi_ok     <= 1'b0;
        sq_ok     <= 1'b0;
        mfc_known <= 1'b0;
        mfi2_err  <= 1'b0;
        if (have_prev && match) begin
          if (good_cnt == CW'(LOCK_GOOD - 1)) begin
            in_frame <= 1'b1;
            good_cnt <= '0;
          end else good_cnt <= good_cnt + 1'b1;
        end else good_cnt <= '0;
      end else begin
        cur_fc <= exp_fc;
        exp_fc <= exp_fc + 4'd1;
        if (exp_fc == 4'd0) mfc <= mfc + 8'd1;
        if (match && rx_fc == 4'd0)  hi_nib <= rx_nib;
        if (match && rx_fc == 4'd14) sq_nib <= rx_nib;
        if (match && rx_fc == 4'd1 && hi_ok) begin
          mfc       <= {hi_nib, rx_nib};
          mfi2_err  <= mfc_known && ({hi_nib, rx_nib} != mfc);
          mfc_known <= 1'b1;
        end
        if (match && rx_fc == 4'd15 && sq_ok) seq_num <= {sq_nib, rx_nib};
        hi_ok <= match && rx_fc == 4'd0;
        sq_ok <= match && rx_fc == 4'd14;
        if (match) bad_cnt <= '0;
        else if (bad_cnt == CW'(LOSS_BAD - 1)) begin
          in_frame  <= 1'b0;
          bad_cnt   <= '0;
          exp_fc    <= rx_fc + 4'd1;
          mfc_known <= 1'b0;
          mfi2_err  <= 1'b0;
          hi_ok     <= 1'b0;
          sq_ok     <= 1'b0;
        end else bad_cnt <= bad_cnt + 1'b1;
      end
    end
  end

  a_r4_fc_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame && h4_vld |=> mf_index[3:0] == $past(mf_index[3:0]) + 4'd1);
  a_r4_mf_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame && h4_vld && mf_index[3:0] == 4'd15 |=> mf_index[11:4] == $past(mf_index[11:4]) + 8'd1);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !h4_vld |=> $stable(mf_index) && $stable(seq_num) && $stable(mfi2_err));
  a_r2_lock_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !h4_vld |=> $stable(in_frame));
  a_r9_err_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mfi2_err |-> in_frame);
endmodule

// File: tb/hovcat_rx_bench.sv
module hovcat_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, h4_vld = 1'b0;
  logic [7:0] h4_byte = '0;
  logic [11:0] mf_index;
  logic [7:0] seq_num;
  logic in_frame, loss_mf, mfi2_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hovcat_rx u_hovcat_rx (.clk, .rst_n, .h4_vld, .h4_byte, .mf_index, .seq_num,
                         .in_frame, .loss_mf, .mfi2_err);

  logic [3:0] m_exp, m_idx1, m_hi, m_sqhi, tx_fc;
  logic [7:0] m_mfc, m_sq, tx_mfc, tx_sq;
  logic m_lock, m_have, m_ghi, m_gsq, m_known, m_err;
  int m_g, m_b;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_exp = 0; m_idx1 = 0; m_hi = 0; m_sqhi = 0; m_mfc = 0; m_sq = 0;
    m_lock = 0; m_have = 0; m_ghi = 0; m_gsq = 0; m_known = 0; m_err = 0;
    m_g = 0; m_b = 0;
  endtask

  task automatic m_step(input logic [7:0] b);
    logic [3:0] r, n, oe;
    logic mt;
    r = b[3:0]; n = b[7:4]; mt = (r == m_exp);
    if (!m_lock) begin
      m_idx1 = r; m_exp = r + 4'd1;
      if (m_have && mt) begin
        if (m_g == 1) begin m_lock = 1; m_g = 0; end else m_g++;
      end else m_g = 0;
      m_have = 1; m_ghi = 0; m_gsq = 0; m_known = 0; m_err = 0;
    end else begin
      oe = m_exp; m_idx1 = oe; m_exp = oe + 4'd1;
      if (oe == 0) m_mfc = m_mfc + 8'd1;
      if (mt && r == 1 && m_ghi) begin
        m_err = m_known && ({m_hi, n} != m_mfc);
        m_mfc = {m_hi, n}; m_known = 1;
      end
      if (mt && r == 15 && m_gsq) m_sq = {m_sqhi, n};
      if (mt && r == 0) m_hi = n;
      if (mt && r == 14) m_sqhi = n;
      m_ghi = mt && r == 0; m_gsq = mt && r == 14;
      if (mt) m_b = 0;
      else if (m_b == 2) begin
        m_lock = 0; m_b = 0; m_exp = r + 4'd1;
        m_known = 0; m_err = 0; m_ghi = 0; m_gsq = 0;
      end else m_b++;
    end
  endtask

  function automatic logic [7:0] tx_byte(input logic [3:0] fc, input logic [7:0] mc,
                                         input logic [7:0] sq);
    logic [3:0] d;
    case (fc)
      4'd0:  d = mc[7:4];
      4'd1:  d = mc[3:0];
      4'd14: d = sq[7:4];
      4'd15: d = sq[3:0];
      default: d = 4'd0;
    endcase
    return {d, fc};
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); h4_vld = 1'b1; h4_byte = b;
    @(negedge clk); h4_vld = 1'b0; h4_byte = $urandom;
    m_step(b);
  endtask

  task automatic send_tx();
    send(tx_byte(tx_fc, tx_mfc, tx_sq));
    tx_fc = tx_fc + 4'd1;
    if (tx_fc == 0) tx_mfc = tx_mfc + 8'd1;
  endtask

  task automatic cmp_model(input string ctx);
    chk({ctx, " R4 index"}, mf_index, {m_mfc, m_idx1});
    chk({ctx, " R6 seq"}, seq_num, m_sq);
    chk({ctx, " R3 lock"}, in_frame, m_lock);
    chk({ctx, " R7 err"}, mfi2_err, m_err);
    chk({ctx, " R8 loss"}, loss_mf, !in_frame);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset index", mf_index, 0);
    chk("R8 reset seq", seq_num, 0);
    chk("R8 reset lock", in_frame, 0);
    chk("R8 reset loss", loss_mf, 1);
    chk("R8 reset err", mfi2_err, 0);

    tx_fc = 4'd13; tx_mfc = 8'h39; tx_sq = 8'h5C;
    send_tx(); send_tx();
    chk("R2 no lock after one step", in_frame, 0);
    send_tx();
    chk("R2 lock after two steps", in_frame, 1);
    while (tx_fc != 4'd2) send_tx();
    chk("R5 mfi2 loaded", mf_index, 12'h3A1);
    chk("R7 first load no err", mfi2_err, 0);
    while (tx_fc != 4'd0) send_tx();
    chk("R6 seq loaded", seq_num, 8'h5C);
    chk("R4 wrap index", mf_index, 12'h3AF);
    send_tx();
    chk("R4 carry", mf_index, 12'h3B0);
    send_tx();
    chk("R7 consistent count", mfi2_err, 0);
    repeat (4) @(negedge clk);
    chk("R8 idle hold", mf_index, 12'h3B1);

    while (tx_fc != 4'd0) send_tx();
    tx_mfc = tx_mfc + 8'd5;
    send_tx(); send_tx();
    chk("R7 jump flagged", mfi2_err, 1);
    chk("R5 jumped value loaded", mf_index[11:4], tx_mfc);

    while (tx_fc != 4'd0) send_tx();
    send(8'hF7);
    tx_fc = tx_fc + 4'd1;
    send_tx();
    chk("R5 no load without frame 0", mf_index[11:4], tx_mfc);
    chk("R3 one miss keeps lock", in_frame, 1);

    while (tx_fc != 4'd14) send_tx();
    tx_sq = 8'hA7;
    send(8'h05); tx_fc = tx_fc + 4'd1;
    send_tx();
    chk("R6 no seq load without frame 14", seq_num, 8'h5C);

    send(8'h09); send(8'h09);
    chk("R3 two misses keep lock", in_frame, 1);
    send(8'h09);
    chk("R3 three misses drop lock", in_frame, 0);
    chk("R8 loss flag", loss_mf, 1);
    chk("R9 err cleared", mfi2_err, 0);
    tx_fc = 4'd10;
    cmp_model("R1 relock");

    for (int i = 0; i < 4000; i++) begin
      k = $urandom_range(0, 99);
      if (k < 8) begin
        send($urandom); tx_fc = tx_fc + 4'd1;
      end else if (k < 9) begin
        for (int j = 0; j < 3; j++) begin send($urandom); tx_fc = tx_fc + 4'd1; end
      end else if (k < 10) begin
        tx_fc = $urandom; send_tx();
      end else if (k < 11) begin
        tx_mfc = $urandom; send_tx();
      end else begin
        if (tx_fc == 4'd14 && k < 30) tx_sq = $urandom;
        send_tx();
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      cmp_model("R1 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule